// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a single-data-rate SDRAM from reset until the memory is ready for normal traffic. After reset it keeps the bus idle for a configurable start-up pause with the clock-enable and data-mask pins high. It then closes every bank and loads the mode register. It also issues the required batch of auto-refresh commands, either before or after the mode-register load as a parameter selects. When the last wait has expired it raises a sticky done flag. From then on it drives NOP, so that a separate access controller can take over the command bus.

Every spacing rule is a parameter counted in clock cycles: the precharge period, the refresh-to-refresh period and the mode-register set time. The pause length is derived from the clock frequency and the pause duration in microseconds. The mode-register contents (CAS latency, burst length, burst ordering, single-write option) are parameters too. They are packed onto the address bus when the mode-register command is issued.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low, and for PAUSE_CYCLES = CLK_MHZ*PAUSE_US cycles after it is released, the command on {cs_n, ras_n, cas_n, we_n} is NOP (4'b0111), every DQM pin is high and init_done is low.
- R2: In the cycle that follows the pause, exactly one precharge-all command is issued. Its code is 4'b0010, the address bus is zero except bit 10, which is high, and the bank address is zero.
- R3: The clock-enable pin is high during reset and in every cycle after it, so it is high for more than one clock before the mode-register command.
- R4: After a precharge the next command comes exactly T_RP cycles later. After an auto-refresh it comes exactly T_RC cycles later, and after a mode-register load exactly T_MRD cycles later. Every cycle in between carries NOP with the address and bank address at zero.
- R5: Exactly REFRESH_COUNT (default 8) auto-refresh commands (4'b0001, address zero) are issued, spaced T_RC apart. If REFRESH_FIRST is 1 they follow the precharge and come before the mode-register load. If it is 0 they follow the mode-register load.
- R6: Exactly one mode-register command (4'b0000) is issued, and only after the precharge-all command.
- R7: The mode-register command carries the following on the address bus, with zeros in all other bits and in the bank address:
  - bits 2:0 hold the burst-length code: 1→000, 2→001, 4→010, 8→011, full page (BURST_LEN=0)→111;
  - bit 3 holds BURST_INTERLEAVE;
  - bits 6:4 hold CAS_LAT (2 or 3);
  - bit 9 holds SINGLE_WRITE (burst read, single-location write).
- R8: init_done rises one cycle after the final wait ends, that is exactly the matching delay after the last command. It then stays high, and the command stays NOP, until the next reset.
- R9: The DQM pins go low in the precharge cycle and stay low.
- R10: Asserting reset in the middle of the sequence returns every pin to its reset value and restarts the whole sequence from the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all logic on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ba | output | BA_W | SDRAM bank address |
| sd_addr | output | ADDR_W | SDRAM address bus |
| sd_dqm | output | DQM_W | SDRAM data mask pins |
| init_done | output | 1 | High from the end of initialization until reset |

## Verification
The bench builds two copies side by side, both with a 200-cycle pause (200 MHz, 1 µs). The first places the refreshes before the mode load, with T_RP=3, T_RC=7 and T_MRD=2, CAS latency 3, burst length 8 and the single-write option. The second places them after, with T_RP=2, T_RC=5 and T_MRD=3, CAS latency 2, full-page bursts and interleaved ordering. Because the delays are unequal, any off-by-one in a wait timer or a swapped phase order moves a command to a cycle the bench does not expect. The short pause keeps the whole sequence, a reset in the middle of the refresh phase and the full second run within a few hundred cycles. The two mode words exercise every field position.

// File: rtl/sdram_init_pkg.sv
// Shared types for the SDRAM power-up sequencer.
// Assumes a command is encoded on {cs_n, ras_n, cas_n, we_n}.
package sdram_init_pkg;

    typedef enum logic [3:0] {
        CMD_MODE_SET  = 4'b0000,
        CMD_AUTO_REF  = 4'b0001,
        CMD_PRECHARGE = 4'b0010,
        CMD_NOP       = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_PRECHARGE,
        ST_WAIT_RP,
        ST_REFRESH,
        ST_WAIT_RC,
        ST_MODE_SET,
        ST_WAIT_MRD,
        ST_DONE
    } init_state_e;

    // Address bit that selects "all banks" on a precharge command.
    localparam int ALL_BANKS_BIT = 10;

endpackage

// File: rtl/sdram_init_mode_word.sv
// Builds the constant mode-register word from the parameters.
// Assumes ADDR_W >= 10. Illegal CAS latency or burst length stops elaboration.
module sdram_init_mode_word #(
    parameter int ADDR_W           = 13,
    parameter int CAS_LAT          = 3,
    parameter int BURST_LEN        = 1,   // 0 selects full page
    parameter int BURST_INTERLEAVE = 0,
    parameter int SINGLE_WRITE     = 0
) (
    output logic [ADDR_W-1:0] mode_word
);
    localparam logic [2:0] BL_CODE = (BURST_LEN == 1) ? 3'b000 :
                                     (BURST_LEN == 2) ? 3'b001 :
                                     (BURST_LEN == 4) ? 3'b010 :
                                     (BURST_LEN == 8) ? 3'b011 : 3'b111;

    generate
        if (CAS_LAT != 2 && CAS_LAT != 3) begin : g_bad_cas
            $error("CAS_LAT must be 2 or 3");
        end
        if (BURST_LEN != 0 && BURST_LEN != 1 && BURST_LEN != 2 &&
            BURST_LEN != 4 && BURST_LEN != 8) begin : g_bad_bl
            $error("BURST_LEN must be 0 (full page), 1, 2, 4 or 8");
        end
    endgenerate

    // Pack the fields into their address positions.
    always_comb begin
        mode_word      = '0;
        mode_word[2:0] = BL_CODE;
        mode_word[3]   = (BURST_INTERLEAVE != 0);
        mode_word[6:4] = 3'(CAS_LAT);
        mode_word[9]   = (SINGLE_WRITE != 0);
    end

endmodule

// File: rtl/sdram_init_timer.sv
// Down counter shared by all wait phases.
// Starts at RESET_VAL in reset, reloads on load, holds at zero.
module sdram_init_timer #(
    parameter int          W         = 16,
    parameter int unsigned RESET_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Count down toward zero; a load takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= W'(RESET_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
// Phase sequencer: pause, precharge, refresh batch and mode load in a fixed order.
// Assumes every delay is at least 2 cycles. Each issue state loads the timer
// with delay-2, so the next command lands exactly "delay" cycles later.
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int TW            = 16,
    parameter int REFRESH_FIRST = 1,
    parameter int REFRESH_COUNT = 8,
    parameter int T_RP          = 2,
    parameter int T_RC          = 6,
    parameter int T_MRD         = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output init_state_e   state_d
);
    localparam int RCW = $clog2(REFRESH_COUNT + 1);

    init_state_e    state_q;
    logic [RCW-1:0] ref_cnt_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PAUSE;
        else        state_q <= state_d;
    end

    // Count the auto-refresh commands issued so far.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ref_cnt_q <= '0;
        else if (state_q == ST_REFRESH) ref_cnt_q <= ref_cnt_q + 1'b1;
    end

    // Next-state and timer-load decode.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_PAUSE: begin
                if (tmr_zero) state_d = ST_PRECHARGE;
            end
            ST_PRECHARGE: begin
                tmr_load = 1'b1;
                tmr_val  = TW'(T_RP - 2);
                state_d  = ST_WAIT_RP;
            end
            ST_WAIT_RP: begin
                if (tmr_zero) state_d = (REFRESH_FIRST != 0) ? ST_REFRESH : ST_MODE_SET;
            end
            ST_REFRESH: begin
                tmr_load = 1'b1;
                tmr_val  = TW'(T_RC - 2);
                state_d  = ST_WAIT_RC;
            end
            ST_WAIT_RC: begin
                if (tmr_zero) begin
                    if (ref_cnt_q == RCW'(REFRESH_COUNT))
                        state_d = (REFRESH_FIRST != 0) ? ST_MODE_SET : ST_DONE;
                    else
                        state_d = ST_REFRESH;
                end
            end
            ST_MODE_SET: begin
                tmr_load = 1'b1;
                tmr_val  = TW'(T_MRD - 2);
                state_d  = ST_WAIT_MRD;
            end
            ST_WAIT_MRD: begin
                if (tmr_zero) state_d = (REFRESH_FIRST != 0) ? ST_DONE : ST_REFRESH;
            end
            ST_DONE: begin
                state_d = ST_DONE;
            end
            default: begin
                state_d = ST_PAUSE;
            end
        endcase
    end

endmodule

// File: rtl/sdram_init_pins.sv
// Pin register: turns the next state into registered command, address,
// mask and done outputs, so each pin changes in the cycle the state is entered.
module sdram_init_pins
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2,
    parameter int DQM_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  init_state_e       state_d,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              sd_cke,
    output logic [3:0]        sd_cmd,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic              init_done
);
    sd_cmd_e           cmd_d;
    logic [ADDR_W-1:0] addr_d;

    // Command and address for the state being entered.
    always_comb begin
        cmd_d  = CMD_NOP;
        addr_d = '0;
        unique case (state_d)
            ST_PRECHARGE: begin
                cmd_d                 = CMD_PRECHARGE;
                addr_d[ALL_BANKS_BIT] = 1'b1;
            end
            ST_REFRESH:  cmd_d = CMD_AUTO_REF;
            ST_MODE_SET: begin
                cmd_d  = CMD_MODE_SET;
                addr_d = mode_word;
            end
            default: begin
                cmd_d  = CMD_NOP;
                addr_d = '0;
            end
        endcase
    end

    // Output registers; reset puts the bus in the power-up idle condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_cke    <= 1'b1;
            sd_cmd    <= CMD_NOP;
            sd_ba     <= '0;
            sd_addr   <= '0;
            sd_dqm    <= '1;
            init_done <= 1'b0;
        end else begin
            sd_cke    <= 1'b1;
            sd_cmd    <= cmd_d;
            sd_ba     <= '0;
            sd_addr   <= addr_d;
            sd_dqm    <= (state_d == ST_PAUSE) ? '1 : '0;
            init_done <= (state_d == ST_DONE);
        end
    end

endmodule

// File: rtl/sdram_init_seq.sv
// SDRAM power-up initialization sequencer (top).
// Assumes a synchronous active-low reset, delays of at least 2 cycles,
// and a pause of at least 2 cycles.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ          = 100,
    parameter int PAUSE_US         = 200,
    parameter int CAS_LAT          = 3,
    parameter int BURST_LEN        = 1,
    parameter int BURST_INTERLEAVE = 0,
    parameter int SINGLE_WRITE     = 0,
    parameter int REFRESH_FIRST    = 1,
    parameter int REFRESH_COUNT    = 8,
    parameter int T_RP             = 2,
    parameter int T_RC             = 6,
    parameter int T_MRD            = 2,
    parameter int ADDR_W           = 13,
    parameter int BA_W             = 2,
    parameter int DQM_W            = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic              init_done
);
    localparam int PAUSE_CYCLES = CLK_MHZ * PAUSE_US;
    localparam int MAX_DLY      = (T_RP > T_RC) ? ((T_RP > T_MRD) ? T_RP : T_MRD)
                                                : ((T_RC > T_MRD) ? T_RC : T_MRD);
    localparam int MAX_CNT      = (PAUSE_CYCLES > MAX_DLY) ? PAUSE_CYCLES : MAX_DLY;
    localparam int TW           = $clog2(MAX_CNT + 1);

    generate
        if (T_RP < 2 || T_RC < 2 || T_MRD < 2 || PAUSE_CYCLES < 2) begin : g_bad_dly
            $error("Delays and pause must be at least 2 cycles");
        end
        if (ADDR_W < 11) begin : g_bad_aw
            $error("ADDR_W must reach the all-banks bit");
        end
    endgenerate

    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_zero;
    init_state_e       state_d;
    logic [ADDR_W-1:0] mode_word;
    logic [3:0]        sd_cmd;

    sdram_init_timer #(
        .W         (TW),
        .RESET_VAL (PAUSE_CYCLES - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sdram_init_fsm #(
        .TW            (TW),
        .REFRESH_FIRST (REFRESH_FIRST),
        .REFRESH_COUNT (REFRESH_COUNT),
        .T_RP          (T_RP),
        .T_RC          (T_RC),
        .T_MRD         (T_MRD)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .state_d  (state_d)
    );

    sdram_init_mode_word #(
        .ADDR_W           (ADDR_W),
        .CAS_LAT          (CAS_LAT),
        .BURST_LEN        (BURST_LEN),
        .BURST_INTERLEAVE (BURST_INTERLEAVE),
        .SINGLE_WRITE     (SINGLE_WRITE)
    ) u_mode (
        .mode_word (mode_word)
    );

    sdram_init_pins #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W),
        .DQM_W  (DQM_W)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_d   (state_d),
        .mode_word (mode_word),
        .sd_cke    (sd_cke),
        .sd_cmd    (sd_cmd),
        .sd_ba     (sd_ba),
        .sd_addr   (sd_addr),
        .sd_dqm    (sd_dqm),
        .init_done (init_done)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = sd_cmd;

endmodule

// File: rtl/sdram_init_seq_chk.sv
// Protocol checker for sdram_init_seq, attached by bind below.
// Watches only the pins and keeps its own counters.
module sdram_init_seq_chk
    import sdram_init_pkg::*;
#(
    parameter int PAUSE_CYCLES     = 20000,
    parameter int T_RP             = 2,
    parameter int T_RC             = 6,
    parameter int T_MRD            = 2,
    parameter int REFRESH_COUNT    = 8,
    parameter int CAS_LAT          = 3,
    parameter int BURST_LEN        = 1,
    parameter int BURST_INTERLEAVE = 0,
    parameter int SINGLE_WRITE     = 0,
    parameter int ADDR_W           = 13,
    parameter int BA_W             = 2,
    parameter int DQM_W            = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [BA_W-1:0]   sd_ba,
    input logic [ADDR_W-1:0] sd_addr,
    input logic [DQM_W-1:0]  sd_dqm,
    input logic              init_done
);
    function automatic logic [ADDR_W-1:0] expected_mode();
        logic [ADDR_W-1:0] w;
        w = '0;
        case (BURST_LEN)
            1:       w[2:0] = 3'd0;
            2:       w[2:0] = 3'd1;
            4:       w[2:0] = 3'd2;
            8:       w[2:0] = 3'd3;
            default: w[2:0] = 3'd7;
        endcase
        w[3]   = (BURST_INTERLEAVE != 0);
        w[6:4] = (CAS_LAT == 2) ? 3'd2 : 3'd3;
        w[9]   = (SINGLE_WRITE != 0);
        return w;
    endfunction

    localparam logic [ADDR_W-1:0] EXP_MODE = expected_mode();
    localparam int RCW = $clog2(REFRESH_COUNT + 1);

    logic [3:0]     cmd;
    logic [31:0]    since_rst_q;
    logic [15:0]    gap_q;
    logic [3:0]     last_q;
    logic           have_prev_q;
    logic           pre_seen_q;
    logic [RCW:0]   refs_q;
    logic [15:0]    need;

    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    // Cycles since reset, saturating at the pause length.
    always_ff @(posedge clk) begin
        if (!rst_n)                          since_rst_q <= '0;
        else if (since_rst_q < PAUSE_CYCLES) since_rst_q <= since_rst_q + 1'b1;
    end

    // Distance to and type of the last non-NOP command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q       <= '0;
            last_q      <= CMD_NOP;
            have_prev_q <= 1'b0;
        end else if (cmd != CMD_NOP) begin
            gap_q       <= 16'd1;
            last_q      <= cmd;
            have_prev_q <= 1'b1;
        end else if (gap_q != 16'hFFFF) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // Precharge seen and refresh tally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_seen_q <= 1'b0;
            refs_q     <= '0;
        end else begin
            if (cmd == CMD_PRECHARGE) pre_seen_q <= 1'b1;
            if (cmd == CMD_AUTO_REF)  refs_q     <= refs_q + 1'b1;
        end
    end

    // Delay owed by the last command.
    always_comb begin
        case (last_q)
            CMD_PRECHARGE: need = 16'(T_RP);
            CMD_AUTO_REF:  need = 16'(T_RC);
            default:       need = 16'(T_MRD);
        endcase
    end

    assert_pause_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q < PAUSE_CYCLES) |-> (cmd == CMD_NOP && sd_dqm == '1 && !init_done));

    assert_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP && have_prev_q) |-> (gap_q >= need));

    assert_refresh_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_AUTO_REF) |-> (refs_q < (RCW+1)'(REFRESH_COUNT)));

    assert_mode_after_pre_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MODE_SET) |-> pre_seen_q);

    assert_mode_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MODE_SET) |-> (sd_addr == EXP_MODE && sd_ba == '0));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cmd == CMD_NOP && sd_cke &&
                       refs_q == (RCW+1)'(REFRESH_COUNT)));

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
    .PAUSE_CYCLES     (PAUSE_CYCLES),
    .T_RP             (T_RP),
    .T_RC             (T_RC),
    .T_MRD            (T_MRD),
    .REFRESH_COUNT    (REFRESH_COUNT),
    .CAS_LAT          (CAS_LAT),
    .BURST_LEN        (BURST_LEN),
    .BURST_INTERLEAVE (BURST_INTERLEAVE),
    .SINGLE_WRITE     (SINGLE_WRITE),
    .ADDR_W           (ADDR_W),
    .BA_W             (BA_W),
    .DQM_W            (DQM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sd_cke    (sd_cke),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_ba     (sd_ba),
    .sd_addr   (sd_addr),
    .sd_dqm    (sd_dqm),
    .init_done (init_done)
);

// File: tb/sdram_init_seq_bench.sv
`timescale 1ns/1ps
// Directed bench: two configurations, full runs and a mid-sequence reset.
module sdram_init_seq_bench;

    localparam int P     = 200;   // 200 MHz * 1 us
    localparam int NLOG  = 320;
    localparam int C_NOP = 7, C_PRE = 2, C_REF = 1, C_MRS = 0;
    // Configuration A: refresh first
    localparam int A_RP = 3, A_RC = 7, A_MRD = 2;
    localparam int A_MODE = 'h233;  // BL8, seq, CL3, single write
    // Configuration B: mode first
    localparam int B_RP = 2, B_RC = 5, B_MRD = 3;
    localparam int B_MODE = 'h02F;  // full page, interleave, CL2

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        a_cke, a_cs, a_ras, a_cas, a_we, a_done;
    logic [1:0]  a_ba, a_dqm;
    logic [12:0] a_addr;
    logic        b_cke, b_cs, b_ras, b_cas, b_we, b_done;
    logic [1:0]  b_ba, b_dqm;
    logic [12:0] b_addr;

    sdram_init_seq #(
        .CLK_MHZ(200), .PAUSE_US(1), .CAS_LAT(3), .BURST_LEN(8),
        .BURST_INTERLEAVE(0), .SINGLE_WRITE(1), .REFRESH_FIRST(1),
        .T_RP(A_RP), .T_RC(A_RC), .T_MRD(A_MRD)
    ) u_sdram_init_seq (
        .clk(clk), .rst_n(rst_n), .sd_cke(a_cke), .sd_cs_n(a_cs),
        .sd_ras_n(a_ras), .sd_cas_n(a_cas), .sd_we_n(a_we), .sd_ba(a_ba),
        .sd_addr(a_addr), .sd_dqm(a_dqm), .init_done(a_done)
    );

    sdram_init_seq #(
        .CLK_MHZ(200), .PAUSE_US(1), .CAS_LAT(2), .BURST_LEN(0),
        .BURST_INTERLEAVE(1), .SINGLE_WRITE(0), .REFRESH_FIRST(0),
        .T_RP(B_RP), .T_RC(B_RC), .T_MRD(B_MRD)
    ) u_sdram_init_seq_alt (
        .clk(clk), .rst_n(rst_n), .sd_cke(b_cke), .sd_cs_n(b_cs),
        .sd_ras_n(b_ras), .sd_cas_n(b_cas), .sd_we_n(b_we), .sd_ba(b_ba),
        .sd_addr(b_addr), .sd_dqm(b_dqm), .init_done(b_done)
    );

    int n_checks = 0;
    int n_fail   = 0;
    // record: {done, cke, dqm[1:0], ba[1:0], addr[12:0], cmd[3:0]}
    logic [22:0] log_a [NLOG];
    logic [22:0] log_b [NLOG];

    task automatic check(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    // Expected command for cycle n after reset release.
    function automatic int exp_cmd(int n, int trp, int trc, int tmrd, bit rf);
        int t0 = P + trp;
        if (n == P) return C_PRE;
        if (rf) begin
            for (int i = 0; i < 8; i++) if (n == t0 + i*trc) return C_REF;
            if (n == t0 + 8*trc) return C_MRS;
        end else begin
            if (n == t0) return C_MRS;
            for (int i = 0; i < 8; i++) if (n == t0 + tmrd + i*trc) return C_REF;
        end
        return C_NOP;
    endfunction

    // Release reset at a falling edge and record NLOG cycles of both copies.
    task automatic run_and_log();
        @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < NLOG; n++) begin
            log_a[n] = {a_done, a_cke, a_dqm, a_ba, a_addr, a_cs, a_ras, a_cas, a_we};
            log_b[n] = {b_done, b_cke, b_dqm, b_ba, b_addr, b_cs, b_ras, b_cas, b_we};
            @(negedge clk);
        end
    endtask

    // Compare one recorded run against the expected sequence.
    task automatic check_log(input bit alt);
        int trp  = alt ? B_RP  : A_RP;
        int trc  = alt ? B_RC  : A_RC;
        int tmrd = alt ? B_MRD : A_MRD;
        bit rf   = !alt;
        int mode = alt ? B_MODE : A_MODE;
        int done_at = P + trp + tmrd + 8*trc;
        for (int n = 0; n < NLOG; n++) begin
            logic [22:0] r = alt ? log_b[n] : log_a[n];
            int ec = exp_cmd(n, trp, trc, tmrd, rf);
            int ea = (ec == C_PRE) ? 'h400 : (ec == C_MRS) ? mode : 0;
            string rq;
            if (n < P)               rq = "R1";
            else if (ec == C_PRE)    rq = "R2";
            else if (ec == C_REF)    rq = "R5";
            else if (ec == C_MRS)    rq = "R6";
            else if (n >= done_at)   rq = "R8";
            else                     rq = "R4";
            check(rq, $sformatf("%s cmd @%0d", alt ? "B" : "A", n), int'(r[3:0]), ec);
            check((ec == C_MRS) ? "R7" : rq, $sformatf("%s addr @%0d", alt ? "B" : "A", n),
                  int'(r[16:4]), ea);
            check("R7", $sformatf("bank @%0d", n), int'(r[18:17]), 0);
            check((n < P) ? "R1" : "R9", $sformatf("dqm @%0d", n), int'(r[20:19]), (n < P) ? 3 : 0);
            check("R3", $sformatf("cke @%0d", n), int'(r[21]), 1);
            check("R8", $sformatf("done @%0d", n), int'(r[22]), (n >= done_at) ? 1 : 0);
        end
    endtask

    // Scenario: pins while reset is held (R1, R3).
    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "A cmd in reset", int'({a_cs, a_ras, a_cas, a_we}), C_NOP);
        check("R1", "B cmd in reset", int'({b_cs, b_ras, b_cas, b_we}), C_NOP);
        check("R1", "A dqm in reset", int'(a_dqm), 3);
        check("R1", "A done in reset", int'(a_done), 0);
        check("R3", "A cke in reset", int'(a_cke), 1);
    endtask

    // Scenario: full sequence, refresh-first (A) and mode-first (B), R2..R9.
    task automatic t_full_run();
        run_and_log();
        check_log(1'b0);
        check_log(1'b1);
    endtask

    // Scenario: reset inside the refresh phase restarts everything (R10).
    task automatic t_mid_reset();
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (230) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R10", "A cmd after mid reset", int'({a_cs, a_ras, a_cas, a_we}), C_NOP);
        check("R10", "A dqm after mid reset", int'(a_dqm), 3);
        check("R10", "A addr after mid reset", int'(a_addr), 0);
        check("R10", "B done after mid reset", int'(b_done), 0);
        run_and_log();
        check_log(1'b0);
        check_log(1'b1);
    endtask

    initial begin
        t_reset_state();
        t_full_run();
        t_mid_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5.0 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule